// File: doc/BRIEF.md
# Core Timer with Watchdog Stages

This block is the free-running time base of a small microcontroller. The bus clock first passes a fixed divide-by-four prescaler. The prescaler steps an 8-bit timer counter, and each wrap of that counter raises a sticky overflow flag. The flag serves directly as the timer interrupt request, so a request arrives every 1024 bus cycles. Software acknowledges the flag with a one-cycle strobe.

Four more divider stages follow the timer counter and advance once per overflow. Together they form a program-health watchdog. A static option input enables it. If software does not clear the stages within 16 overflows, the block emits a one-cycle watchdog reset pulse. Software clears the stages by writing a zero into bit 0 of a shared control register. The same register also holds two write-once option bits. Bit 7 is a security lock, which reads back as zero. Bit 6 enables optional features.

The reset input is asserted asynchronously and released through a two-flop synchronizer. Counting therefore starts on the third rising edge after the reset input goes high.

Top module: `core_timer_wdog`

## Requirements
- R1: `tcnt` advances by one on every fourth active clock edge and wraps from 255 to 0. At the negative edge after active edge k it equals (k/4) mod 256.
- R2: An overflow occurs on the active edge that moves `tcnt` from 255 to 0, which is every 1024th edge. `ovf_flag` is 1 from that edge onward.
- R3: `ovf_flag` stays set until an edge where `flag_ack` is 1 and no overflow occurs. If an overflow and an acknowledge fall on the same edge, the flag stays set.
- R4: With `wdog_en_opt` at 1, each overflow advances the watchdog stages. On the 16th overflow without a clear, the stages wrap to 0 and `wdog_rst` is 1 for exactly the cycle after that edge.
- R5: With `wdog_en_opt` at 0, the watchdog stages are held at zero and `wdog_rst` never rises.
- R6: A write (`cop_wr` = 1) to address 0x1FF0 with data bit 0 equal to 0 clears the watchdog stages. When it lands on an overflow edge, the clear wins, so the next pulse comes 16 overflows later.
- R7: Writes to address 0x1FF0 with data bit 0 equal to 1, and writes to any other address, leave the watchdog stages unchanged.
- R8: The first write to 0x1FF0 after reset captures data bit 7 into `sec_lock` and data bit 6 into `opt_en`. Later writes leave both unchanged. `cop_rdata` returns `opt_en` in bit 6 and 0 in all other bits, bit 7 included.
- R9: While the reset input is low, `tcnt`, `ovf_flag`, `wdog_rst`, `sec_lock`, `opt_en` and `cop_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wdog_en_opt | input | 1 | Static option: 1 enables the watchdog stages |
| cop_wr | input | 1 | Write strobe for the control register |
| cop_addr | input | 16 | Write address; the control register decodes at 0x1FF0 |
| cop_wdata | input | 8 | Write data: bit 7 security lock, bit 6 option enable, bit 0 watchdog clear (active 0) |
| flag_ack | input | 1 | One-cycle acknowledge of the overflow flag |
| tcnt | output | 8 | Timer counter value |
| ovf_flag | output | 1 | Sticky overflow flag, also the timer interrupt request |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |
| cop_rdata | output | 8 | Control register readback |
| sec_lock | output | 1 | Latched security lock bit |
| opt_en | output | 1 | Latched optional-features enable |

## Verification
Every result is registered. The new `tcnt` value, the flag set or clear, and any captured option bits all appear after the edge that sampled the stimulus. `wdog_rst` is high for the cycle after the 16th overflow edge.

The bench counts active edges from the reset release, allowing for the two synchronizer edges. It drives inputs at the falling edge and advances its arithmetic model at the rising edge. It compares every output at the next falling edge.

Timed stimuli are placed at edge counts that are multiples of 1024 minus one. The acknowledge and the watchdog clear therefore land on exact overflow edges. The cycle of the expected pulse, 16384 edges after the last clear, is checked by number.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
  localparam int PRE_W  = 2;
  localparam int TCNT_W = 8;
  localparam int WDOG_W = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [15:0] COP_ADDR = 16'h1FF0;
  localparam int BIT_SEC = 7;
  localparam int BIT_OPT = 6;
  localparam int BIT_CLR = 0;

  typedef struct packed {
    logic sec;
    logic opt;
    logic written;
  } cop_opt_t;
endpackage

// File: rtl/ctw_rst_sync.sv
module ctw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ctw_div_stage.sv
module ctw_div_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;
  logic         q_en;

  assign q_en = inc | clr;

  always_comb begin
    q_nx = q_r;
    if (clr)      q_nx = '0;
    else if (inc) q_nx = q_r + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_nx;
  end

  assign q    = q_r;
  assign wrap = inc & ~clr & (q_r == ALL_ONES);

  AST_STAGE_CLR:  assert property (@(posedge clk) disable iff (!rst_n) clr |=> (q_r == '0));        // R6
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!inc && !clr) |=> $stable(q_r)); // R1
endmodule

// File: rtl/ctw_cop_reg.sv
module ctw_cop_reg
  import ctw_pkg::*;
#(
  parameter int              A_W      = 16,
  parameter int              D_W      = 8,
  parameter logic [A_W-1:0]  REG_ADDR = 16'h1FF0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [A_W-1:0] addr,
  input  logic [D_W-1:0] wdata,
  output logic           wdog_clr,
  output logic           sec_lock,
  output logic           opt_en,
  output logic [D_W-1:0] rdata
);
  logic     hit;
  logic     st_en;
  cop_opt_t st_r;
  cop_opt_t st_nx;
  logic     unused_wdata_bits;

  assign hit               = wr & (addr == REG_ADDR);
  assign st_en             = hit & ~st_r.written;
  assign unused_wdata_bits = ^wdata[BIT_OPT-1:BIT_CLR+1];

  always_comb begin
    st_nx         = st_r;
    st_nx.sec     = wdata[BIT_SEC];
    st_nx.opt     = wdata[BIT_OPT];
    st_nx.written = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_r <= '0;
    else if (st_en) st_r <= st_nx;
  end

  assign wdog_clr = hit & ~wdata[BIT_CLR];
  assign sec_lock = st_r.sec;
  assign opt_en   = st_r.opt;

  always_comb begin
    rdata          = '0;
    rdata[BIT_OPT] = st_r.opt;
  end

  AST_OPT_HELD: assert property (@(posedge clk) disable iff (!rst_n) st_r.written |=> $stable(st_r)); // R8
  AST_SEC_HIDE: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |-> (rdata[BIT_SEC] == 1'b0)); // R8
endmodule

// File: rtl/core_timer_wdog.sv
module core_timer_wdog
  import ctw_pkg::*;
#(
  parameter int                 PRE_BITS  = ctw_pkg::PRE_W,
  parameter int                 TCNT_BITS = ctw_pkg::TCNT_W,
  parameter int                 WDOG_BITS = ctw_pkg::WDOG_W,
  parameter int                 ABITS     = ctw_pkg::ADDR_W,
  parameter logic [ABITS-1:0]   REG_ADDR  = ctw_pkg::COP_ADDR
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wdog_en_opt,
  input  logic                 cop_wr,
  input  logic [ABITS-1:0]     cop_addr,
  input  logic [7:0]           cop_wdata,
  input  logic                 flag_ack,
  output logic [TCNT_BITS-1:0] tcnt,
  output logic                 ovf_flag,
  output logic                 wdog_rst,
  output logic [7:0]           cop_rdata,
  output logic                 sec_lock,
  output logic                 opt_en
);
  logic                 rst_q_n;
  logic [PRE_BITS-1:0]  pre_q;
  logic                 pre_wrap;
  logic                 ovf_tick;
  logic [WDOG_BITS-1:0] wdog_q;
  logic                 wdog_wrap;
  logic                 wdog_inc;
  logic                 wdog_clr_sw;
  logic                 wdog_clr;
  logic                 flag_r, flag_nx;
  logic                 wrst_r, wrst_nx;
  logic                 unused_pre_bits;
  logic                 unused_wdog_bits;

  ctw_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  ctw_div_stage #(.W(PRE_BITS)) u_prescale (
    .clk   (clk),
    .rst_n (rst_q_n),
    .inc   (1'b1),
    .clr   (1'b0),
    .q     (pre_q),
    .wrap  (pre_wrap)
  );

  ctw_div_stage #(.W(TCNT_BITS)) u_tcnt (
    .clk   (clk),
    .rst_n (rst_q_n),
    .inc   (pre_wrap),
    .clr   (1'b0),
    .q     (tcnt),
    .wrap  (ovf_tick)
  );

  assign wdog_inc = ovf_tick & wdog_en_opt;
  assign wdog_clr = wdog_clr_sw | ~wdog_en_opt;

  ctw_div_stage #(.W(WDOG_BITS)) u_wdog (
    .clk   (clk),
    .rst_n (rst_q_n),
    .inc   (wdog_inc),
    .clr   (wdog_clr),
    .q     (wdog_q),
    .wrap  (wdog_wrap)
  );

  ctw_cop_reg #(.A_W(ABITS), .D_W(8), .REG_ADDR(REG_ADDR)) u_cop (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr       (cop_wr),
    .addr     (cop_addr),
    .wdata    (cop_wdata),
    .wdog_clr (wdog_clr_sw),
    .sec_lock (sec_lock),
    .opt_en   (opt_en),
    .rdata    (cop_rdata)
  );

  assign unused_pre_bits  = ^pre_q;
  assign unused_wdog_bits = ^wdog_q;

  always_comb begin
    flag_nx = flag_r;
    if (ovf_tick)      flag_nx = 1'b1;
    else if (flag_ack) flag_nx = 1'b0;
    wrst_nx = wdog_wrap;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flag_r <= 1'b0;
      wrst_r <= 1'b0;
    end else begin
      flag_r <= flag_nx;
      wrst_r <= wrst_nx;
    end
  end

  assign ovf_flag = flag_r;
  assign wdog_rst = wrst_r;

  AST_FLAG_SET:   assert property (@(posedge clk) disable iff (!rst_q_n) ovf_tick |=> ovf_flag);                          // R3
  AST_FLAG_HOLD:  assert property (@(posedge clk) disable iff (!rst_q_n) (ovf_flag && !flag_ack) |=> ovf_flag);           // R3
  AST_FLAG_CLR:   assert property (@(posedge clk) disable iff (!rst_q_n) (flag_ack && !ovf_tick) |=> !ovf_flag);          // R3
  AST_WRST_PULSE: assert property (@(posedge clk) disable iff (!rst_q_n) wdog_rst |=> !wdog_rst);                         // R4
  AST_WRST_OFF:   assert property (@(posedge clk) disable iff (!rst_q_n) !wdog_en_opt |=> !wdog_rst);                     // R5
  AST_TCNT_STEP:  assert property (@(posedge clk) disable iff (!rst_q_n) pre_wrap |=> (tcnt == $past(tcnt) + 1'b1));      // R1
endmodule

// File: tb/tb_core_timer_wdog.sv
`timescale 1ns/100ps
module tb_core_timer_wdog;
  localparam logic [15:0] REG_A = 16'h1FF0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wdog_en_opt;
  logic        cop_wr;
  logic [15:0] cop_addr;
  logic [7:0]  cop_wdata;
  logic        flag_ack;
  logic [7:0]  tcnt;
  logic        ovf_flag;
  logic        wdog_rst;
  logic [7:0]  cop_rdata;
  logic        sec_lock;
  logic        opt_en;

  core_timer_wdog dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdog_en_opt (wdog_en_opt),
    .cop_wr      (cop_wr),
    .cop_addr    (cop_addr),
    .cop_wdata   (cop_wdata),
    .flag_ack    (flag_ack),
    .tcnt        (tcnt),
    .ovf_flag    (ovf_flag),
    .wdog_rst    (wdog_rst),
    .cop_rdata   (cop_rdata),
    .sec_lock    (sec_lock),
    .opt_en      (opt_en)
  );

  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int k, rel, wc;
  int pulses  = 0;
  int pulse_k = -1;
  bit e_flag, e_wrst, e_sec, e_opt, e_wr;
  bit tick, clr_m, hit_m;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (k=%0d)", tag, act, exp, k);
    end
  endtask

  // arithmetic model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; k = 0; wc = 0;
      e_flag = 0; e_wrst = 0; e_sec = 0; e_opt = 0; e_wr = 0;
    end else begin
      rel++;
      if (rel >= 3) begin
        tick   = ((k % 1024) == 1023);
        hit_m  = cop_wr && (cop_addr == REG_A);
        clr_m  = hit_m && !cop_wdata[0];
        e_wrst = 0;
        if (!wdog_en_opt) wc = 0;
        else if (clr_m)   wc = 0;
        else if (tick) begin
          if (wc == 15) begin wc = 0; e_wrst = 1; end
          else wc++;
        end
        if (tick)          e_flag = 1;
        else if (flag_ack) e_flag = 0;
        if (hit_m && !e_wr) begin
          e_sec = cop_wdata[7]; e_opt = cop_wdata[6]; e_wr = 1;
        end
        k++;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 tcnt", tcnt, (k / 4) % 256);
      chk("R3 ovf_flag", ovf_flag, e_flag);
      chk("R4 wdog_rst", wdog_rst, e_wrst);
      chk("R8 cop_rdata", cop_rdata, int'(e_opt) * 64);
      chk("R8 sec_lock", sec_lock, e_sec);
      chk("R8 opt_en", opt_en, e_opt);
      if (wdog_rst) begin pulses++; pulse_k = k; end
    end
  end

  task automatic wait_k(input int target);
    while (k != target) @(negedge clk);
  endtask

  task automatic cop_write(input logic [15:0] a, input logic [7:0] d);
    cop_wr = 1'b1; cop_addr = a; cop_wdata = d;
    @(negedge clk);
    cop_wr = 1'b0; cop_addr = '0; cop_wdata = '0;
  endtask

  task automatic check_reset_state();
    chk("R9 tcnt", tcnt, 0);
    chk("R9 ovf_flag", ovf_flag, 0);
    chk("R9 wdog_rst", wdog_rst, 0);
    chk("R9 cop_rdata", cop_rdata, 0);
    chk("R9 sec_lock", sec_lock, 0);
    chk("R9 opt_en", opt_en, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; wdog_en_opt = 0; cop_wr = 0; cop_addr = '0; cop_wdata = '0; flag_ack = 0;
    repeat (5) @(negedge clk);
    check_reset_state();
    rst_n = 1; wdog_en_opt = 1;
    repeat (4) @(negedge clk);

    // first write: option bit captured, clear bit = 1 so no clear
    cop_write(REG_A, 8'h41);
    chk("R8 first write opt", cop_rdata, 8'h40);
    chk("R8 first write sec", sec_lock, 0);
    cop_write(REG_A, 8'hC1);
    chk("R8 later write ignored rdata", cop_rdata, 8'h40);
    chk("R8 later write ignored sec", sec_lock, 0);

    // R2/R3: acknowledge coinciding with an overflow edge
    wait_k(1024);
    chk("R2 flag set at first overflow", ovf_flag, 1);
    wait_k(2047);
    flag_ack = 1;
    @(negedge clk);
    flag_ack = 0;
    chk("R3 overflow wins over ack", ovf_flag, 1);
    wait_k(2500);
    flag_ack = 1;
    @(negedge clk);
    flag_ack = 0;
    chk("R3 ack clears flag", ovf_flag, 0);
    wait_k(3071);
    chk("R2 flag low before overflow", ovf_flag, 0);
    @(negedge clk);
    chk("R2 flag high after overflow", ovf_flag, 1);

    // R4: no clears -> pulse after 16 overflows
    wait_k(16386);
    chk("R4 pulse count", pulses, 1);
    chk("R4 pulse cycle", pulse_k, 16384);

    // R6: periodic clears, each landing on an overflow edge
    for (int i = 0; i < 4; i++) begin
      wait_k(17407 + i * 10240);
      cop_write(REG_A, 8'h00);
    end
    // R7: ineffective writes
    wait_k(50000); cop_write(REG_A, 8'hC1);
    wait_k(55000); cop_write(16'h1FF1, 8'h00);
    wait_k(60000); cop_write(16'h0FF0, 8'h00);
    wait_k(63500);
    chk("R6 no pulse while cleared", pulses, 1);
    wait_k(64514);
    chk("R7 pulse despite ignored writes", pulses, 2);
    chk("R6 clear won over overflow", pulse_k, 64512);

    // R5: watchdog disabled
    wdog_en_opt = 0;
    wait_k(82520);
    chk("R5 no pulse when disabled", pulses, 2);

    // R9 + R8 after a second reset
    rst_n = 0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1; wdog_en_opt = 1;
    repeat (4) @(negedge clk);
    cop_write(REG_A, 8'h81);
    chk("R8 sec captured", sec_lock, 1);
    chk("R8 sec reads 0", cop_rdata, 0);
    cop_write(REG_A, 8'h41);
    chk("R8 sec held", sec_lock, 1);
    chk("R8 opt held", opt_en, 0);
    wait_k(1023);
    chk("R2 flag before overflow", ovf_flag, 0);
    @(negedge clk);
    chk("R2 flag after overflow", ovf_flag, 1);
    chk("R1 tcnt wrapped", tcnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule